// File: doc/BRIEF.md
# Bus Strobe Generator

This block produces the two timing strobes of a byte-wide microcontroller bus: an address-latch strobe that tells external logic when to capture the low address byte, and an active-low read strobe for fetching code from external program memory. It runs on the oscillator clock. Clocks are grouped into machine cycles of six states with two clocks per state, twelve clocks in all, and both strobes are decoded from a position counter that walks through those states.

The address-latch strobe runs freely at one sixth of the clock rate, with two pulses in each machine cycle. The fetch strobe goes active twice in each machine cycle when the core executes from external program memory. A machine cycle that carries an external data access drops the first latch pulse and both fetch activations. Per-cycle requests (external fetch, external data access, latch disable) are captured once at the machine-cycle boundary. Operating-mode flags (data-move and table-read instructions, idle, power-down, emulation) are registered on every clock. They override the latch disable, and in the two low-power modes they override the strobes as well.

When the disable is in force the latch strobe stays low and a weak-pullup enable is raised, so that the pin floats high through a weak pull-up.

Top module: `busstrobe_gen`

## Requirements
- R1: While reset is low, and immediately when it is asserted, the outputs are addr_latch=0, fetch_rd_n=1 and latch_pin_pullup=0. The position counter returns to slot 0, which is state 1, first clock.
- R2: Reset release passes through a two-stage synchronizer, so addr_latch first rises after the third rising edge following release. With slots numbered 0..11 from the start of a machine cycle, addr_latch is 1 in slots 1, 2, 7 and 8 and 0 in the other slots. This gives a period of six clocks.
- R3: In a machine cycle whose captured ext_fetch is 1 and ext_data is 0, fetch_rd_n is 0 in slots 4, 5, 10 and 11 and 1 in the other slots. In any other cycle, fetch_rd_n stays 1.
- R4: In a machine cycle whose captured ext_data is 1, the slot 1-2 latch pulse is dropped, the slot 7-8 pulse is kept, and fetch_rd_n stays 1 for the whole cycle.
- R5: ext_fetch, ext_data and latch_off are sampled only on the clock edge that enters slot 0. A change made in the middle of a cycle first acts in the next cycle.
- R6: When the captured latch_off is 1 and nothing overrides it, addr_latch is 0 for the whole cycle and latch_pin_pullup is 1.
- R7: Any of data_move_op, table_read_op or emulate_st overrides latch_off. The latch strobe then runs normally and latch_pin_pullup is 0.
- R8: latch_off has no effect in a machine cycle whose captured ext_fetch is 1.
- R9: While idle_st is active (and powerdown_st is not), addr_latch=1, fetch_rd_n=1 and latch_pin_pullup=0.
- R10: While powerdown_st is active, addr_latch=0, fetch_rd_n=0 and latch_pin_pullup=0. Power-down takes precedence over idle.
- R11: Reset clears the captured disable. The first machine cycle after reset release produces normal latch pulses even when latch_off is held at 1.
- R12: The mode inputs are registered on every clock. A change becomes visible at the outputs after the next rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_fetch | input | 1 | The next machine cycle fetches from external program memory |
| ext_data | input | 1 | The next machine cycle performs an external data access |
| latch_off | input | 1 | Address-latch disable control bit |
| data_move_op | input | 1 | An external data-move instruction is executing |
| table_read_op | input | 1 | A table-read instruction is executing |
| idle_st | input | 1 | The device is in idle |
| powerdown_st | input | 1 | The device is in power-down |
| emulate_st | input | 1 | The device is in emulation mode |
| addr_latch | output | 1 | Address-latch strobe, active high |
| fetch_rd_n | output | 1 | Program-fetch read strobe, active low |
| latch_pin_pullup | output | 1 | Weak pull-up enable for the address-latch pin |

## Verification
Each output depends on where the position counter sits in the machine cycle, so a wrong or slipped counter moves a latch pulse or a fetch activation by one or more slots. That error shows at the ports within one machine cycle, twelve clocks. A captured cycle flag taken at the wrong edge shows up as a missing or extra pulse in the slot right after the intended boundary. A mode register that was skipped or held too long produces a wrong output on the first clock after the mode input changes. For these reasons every slot of every stimulated cycle is compared at the ports against a slot-by-slot prediction.

// File: rtl/busstrobe_pkg.sv
package busstrobe_pkg;
  // six states per machine cycle; latch and fetch windows are tied to this
  localparam int STATES = 6;

  typedef struct packed {
    logic fetch;
    logic data;
    logic off;
  } cyc_flags_t;

  typedef struct packed {
    logic dmove;
    logic tread;
    logic idle;
    logic pdown;
    logic emu;
  } mode_flags_t;
endpackage

// File: rtl/busstrobe_timebase.sv
module busstrobe_timebase
  import busstrobe_pkg::*;
#(
  parameter int PHASES = 2,
  localparam int ST_W = $clog2(STATES),
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [ST_W-1:0] state_idx,
  output logic [PH_W-1:0] phase_idx,
  output logic            cyc_end
);
  logic [ST_W-1:0] state_nx;
  logic [PH_W-1:0] phase_nx;
  logic            last_ph;

  always_comb begin
    last_ph  = (phase_idx == PH_W'(PHASES - 1));
    cyc_end  = last_ph && (state_idx == ST_W'(STATES - 1));
    phase_nx = last_ph ? '0 : phase_idx + 1'b1;
    state_nx = state_idx;
    if (last_ph) begin
      state_nx = cyc_end ? '0 : state_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_idx <= '0;
      phase_idx <= '0;
    end else begin
      state_idx <= state_nx;
      phase_idx <= phase_nx;
    end
  end
endmodule

// File: rtl/busstrobe_cycle_ctl.sv
module busstrobe_cycle_ctl
  import busstrobe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cyc_end,
  input  cyc_flags_t  cyc_in,
  input  mode_flags_t mode_in,
  output cyc_flags_t  cyc_q,
  output mode_flags_t mode_q
);
  cyc_flags_t cyc_nx;

  // per-cycle requests are taken only at the machine-cycle boundary
  always_comb begin
    cyc_nx = cyc_q;
    if (cyc_end) begin
      cyc_nx = cyc_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      mode_q <= '0;
    end else begin
      cyc_q  <= cyc_nx;
      mode_q <= mode_in;
    end
  end
endmodule

// File: rtl/busstrobe_decode.sv
module busstrobe_decode
  import busstrobe_pkg::*;
#(
  parameter int PHASES = 2,
  localparam int ST_W = $clog2(STATES),
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1,
  localparam int HALVES = 2,
  localparam int HALF_ST = STATES / HALVES
) (
  input  logic [ST_W-1:0] state_idx,
  input  logic [PH_W-1:0] phase_idx,
  input  cyc_flags_t      cyc_q,
  input  mode_flags_t     mode_q,
  output logic            addr_latch,
  output logic            fetch_rd_n,
  output logic            latch_pin_pullup
);
  logic [HALVES-1:0] latch_win;
  logic [HALVES-1:0] fetch_win;

  // each half cycle: latch spans the last clock of its first state and the
  // first clock of its second state; fetch spans its third state
  for (genvar k = 0; k < HALVES; k++) begin : g_half
    assign latch_win[k] =
      ((state_idx == ST_W'(k * HALF_ST))     && (phase_idx == PH_W'(PHASES - 1))) ||
      ((state_idx == ST_W'(k * HALF_ST + 1)) && (phase_idx == '0));
    assign fetch_win[k] = (state_idx == ST_W'(k * HALF_ST + 2));
  end

  logic latch_run;
  logic fetch_run;
  logic off_eff;

  always_comb begin
    // a data cycle drops the first latch pulse and both fetch activations
    latch_run = latch_win[1] || (latch_win[0] && !cyc_q.data);
    fetch_run = (|fetch_win) && cyc_q.fetch && !cyc_q.data;
    off_eff   = cyc_q.off && !cyc_q.fetch && !mode_q.dmove && !mode_q.tread &&
                !mode_q.idle && !mode_q.pdown && !mode_q.emu;

    addr_latch       = latch_run;
    fetch_rd_n       = !fetch_run;
    latch_pin_pullup = 1'b0;
    if (mode_q.pdown) begin
      addr_latch = 1'b0;
      fetch_rd_n = 1'b0;
    end else if (mode_q.idle) begin
      addr_latch = 1'b1;
      fetch_rd_n = 1'b1;
    end else if (off_eff) begin
      addr_latch       = 1'b0;
      latch_pin_pullup = 1'b1;
    end
  end
endmodule

// File: rtl/busstrobe_gen.sv
module busstrobe_gen
  import busstrobe_pkg::*;
#(
  parameter int PHASES     = 2,
  parameter int RST_STAGES = 2,
  localparam int ST_W = $clog2(STATES),
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_fetch,
  input  logic ext_data,
  input  logic latch_off,
  input  logic data_move_op,
  input  logic table_read_op,
  input  logic idle_st,
  input  logic powerdown_st,
  input  logic emulate_st,
  output logic addr_latch,
  output logic fetch_rd_n,
  output logic latch_pin_pullup
);
  // reset: asserted asynchronously, released through a synchronizer
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  logic [ST_W-1:0] state_idx;
  logic [PH_W-1:0] phase_idx;
  logic            cyc_end;
  cyc_flags_t      cyc_in, cyc_q;
  mode_flags_t     mode_in, mode_q;

  assign cyc_in  = '{fetch: ext_fetch, data: ext_data, off: latch_off};
  assign mode_in = '{dmove: data_move_op, tread: table_read_op, idle: idle_st,
                     pdown: powerdown_st, emu: emulate_st};

  busstrobe_timebase #(.PHASES(PHASES)) u_tb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .state_idx (state_idx),
    .phase_idx (phase_idx),
    .cyc_end   (cyc_end)
  );

  busstrobe_cycle_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cyc_end (cyc_end),
    .cyc_in  (cyc_in),
    .mode_in (mode_in),
    .cyc_q   (cyc_q),
    .mode_q  (mode_q)
  );

  busstrobe_decode #(.PHASES(PHASES)) u_dec (
    .state_idx        (state_idx),
    .phase_idx        (phase_idx),
    .cyc_q            (cyc_q),
    .mode_q           (mode_q),
    .addr_latch       (addr_latch),
    .fetch_rd_n       (fetch_rd_n),
    .latch_pin_pullup (latch_pin_pullup)
  );
endmodule

// File: rtl/busstrobe_gen_chk.sv
module busstrobe_gen_chk
  import busstrobe_pkg::*;
#(
  parameter int PHASES = 2,
  localparam int ST_W = $clog2(STATES),
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [ST_W-1:0] state_idx,
  input logic [PH_W-1:0] phase_idx,
  input cyc_flags_t      cyc_q,
  input mode_flags_t     mode_q,
  input logic            addr_latch,
  input logic            fetch_rd_n,
  input logic            latch_pin_pullup
);
  logic at_start;
  assign at_start = (state_idx == '0) && (phase_idx == '0);

  a_r1_cycle_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_idx == ST_W'(STATES - 1)) && (phase_idx == PH_W'(PHASES - 1)))
      |=> at_start);

  a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !at_start |-> $stable(cyc_q));

  a_r3_fetch_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_rd_n && !mode_q.pdown) |-> ((state_idx == ST_W'(2)) || (state_idx == ST_W'(5))));

  a_r4_data_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q.data && !mode_q.pdown) |-> fetch_rd_n);

  a_r6_pullup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pin_pullup |-> (!addr_latch && !cyc_q.fetch));

  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.idle && !mode_q.pdown) |-> (addr_latch && fetch_rd_n && !latch_pin_pullup));

  a_r10_pdown_low: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.pdown |-> (!addr_latch && !fetch_rd_n && !latch_pin_pullup));
endmodule

bind busstrobe_gen busstrobe_gen_chk #(.PHASES(PHASES)) u_chk (
  .clk              (clk),
  .rst_n            (rst_sync_n),
  .state_idx        (state_idx),
  .phase_idx        (phase_idx),
  .cyc_q            (cyc_q),
  .mode_q           (mode_q),
  .addr_latch       (addr_latch),
  .fetch_rd_n       (fetch_rd_n),
  .latch_pin_pullup (latch_pin_pullup)
);

// File: tb/busstrobe_gen_tb_top.sv
`timescale 1ns/1ps
module busstrobe_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_fetch = 0, ext_data = 0, latch_off = 0;
  logic data_move_op = 0, table_read_op = 0, idle_st = 0, powerdown_st = 0, emulate_st = 0;
  logic addr_latch, fetch_rd_n, latch_pin_pullup;

  always #10 clk = ~clk;

  busstrobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ext_fetch(ext_fetch), .ext_data(ext_data),
    .latch_off(latch_off), .data_move_op(data_move_op), .table_read_op(table_read_op),
    .idle_st(idle_st), .powerdown_st(powerdown_st), .emulate_st(emulate_st),
    .addr_latch(addr_latch), .fetch_rd_n(fetch_rd_n), .latch_pin_pullup(latch_pin_pullup)
  );

  // {fetch, data, off, dmove, tread, idle, pdown, emu}, one per machine cycle
  localparam int NVEC = 14;
  localparam logic [7:0] VEC [NVEC] = '{
    8'b0000_0000, 8'b1000_0000, 8'b1100_0000, 8'b0100_0000,
    8'b0010_0000, 8'b1010_0000, 8'b0011_0000, 8'b0010_1000,
    8'b0010_0001, 8'b0010_0100, 8'b0000_0010, 8'b1000_0100,
    8'b1000_0110, 8'b0000_0000
  };

  int checks = 0;
  int fails = 0;
  int bslot = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic ea, input logic ef, input logic ep);
    checks++;
    if (addr_latch !== ea || fetch_rd_n !== ef || latch_pin_pullup !== ep) begin
      fails++;
      $display("FAIL %s slot %0d: got latch=%b rd_n=%b pu=%b expected latch=%b rd_n=%b pu=%b",
               tag, bslot, addr_latch, fetch_rd_n, latch_pin_pullup, ea, ef, ep);
    end
  endtask

  task automatic step();
    @(posedge clk);
    bslot = (bslot + 1) % 12;
    @(negedge clk);
  endtask

  task automatic apply(input logic [7:0] v);
    {ext_fetch, ext_data, latch_off, data_move_op, table_read_op, idle_st, powerdown_st, emulate_st} = v;
  endtask

  function automatic logic [2:0] expect_out(input int s, input logic [7:0] v);
    logic f, d, o, dm, tr, id, pd, em, lat, rd_n, pu, off_eff;
    {f, d, o, dm, tr, id, pd, em} = v;
    if (pd) return 3'b000;
    if (id) return 3'b110;
    rd_n = !(f && !d && (s == 4 || s == 5 || s == 10 || s == 11));
    lat  = (s == 7 || s == 8) || (!d && (s == 1 || s == 2));
    off_eff = o && !f && !dm && !tr && !em;
    pu = 1'b0;
    if (off_eff) begin lat = 1'b0; pu = 1'b1; end
    return {lat, rd_n, pu};
  endfunction

  function automatic string tag_of(input logic [7:0] v);
    if (v[1]) return "R10 powerdown";
    if (v[2]) return "R9 idle";
    if (v[5] && v[7]) return "R8 off ignored on ext fetch";
    if (v[5] && (v[4] || v[3] || v[0])) return "R7 off suspended";
    if (v[5]) return "R6 latch off";
    if (v[6]) return "R4 data cycle";
    if (v[7]) return "R3 ext fetch";
    return "R2 free run";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] e;
    repeat (3) @(negedge clk);
    chk("R1 reset state", 1'b0, 1'b1, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2 sync latency hold", 1'b0, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    bslot = 1;
    chk("R2 first latch pulse", 1'b1, 1'b1, 1'b0);
    while (bslot != 11) step();

    // table of whole machine cycles
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i]);
      for (int s = 0; s < 12; s++) begin
        step();
        e = expect_out(bslot, VEC[i]);
        chk(tag_of(VEC[i]), e[2], e[1], e[0]);
      end
    end
    apply(8'h00);

    // R12: mode inputs act after the next edge
    while (bslot != 3) step();
    idle_st = 1'b1;
    #1 chk("R12 idle not yet", 1'b0, 1'b1, 1'b0);
    step();
    chk("R12 idle after edge", 1'b1, 1'b1, 1'b0);
    idle_st = 1'b0;
    step();
    chk("R12 idle released", 1'b0, 1'b1, 1'b0);

    // R5: disable raised mid-cycle waits for the boundary
    latch_off = 1'b1;
    step(); step();
    chk("R5 mid-cycle off ignored", 1'b1, 1'b1, 1'b0);
    while (bslot != 0) step();
    chk("R5 off at boundary", 1'b0, 1'b1, 1'b1);
    step();
    chk("R5 off holds pulse", 1'b0, 1'b1, 1'b1);

    // R1/R11: async reset during a disabled cycle, disable input kept high
    rst_n = 1'b0;
    #1 chk("R1 async reset", 1'b0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R11 cleared during sync", 1'b0, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    bslot = 1;
    chk("R11 first cycle pulses", 1'b1, 1'b1, 1'b0);
    while (bslot != 11) step();
    step(); step();
    chk("R11 off taken next cycle", 1'b0, 1'b1, 1'b1);
    latch_off = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule